// File: doc/BRIEF.md
# Segment Register Translation and Protection Unit

This block keeps six segment registers on chip and turns every memory access made through one of them into a 24-bit physical address, or into a fault. Software fills each register with a 16-bit selector and a 64-bit descriptor. No hardware replacement takes place. An access names a register, gives a 16-bit offset, an access kind and the current privilege level. One cycle later the block returns the translated address or a fault code.

Four checks run on every access. The register must be present. The privilege test uses the larger of the current level and the selector's requested level, so the requested level can only weaken an access. The access kind must match the segment's type bits. The offset must pass the bounds test, which is reversed for expand-down stack segments. The descriptor copy has an accessed bit. This bit is set on the first clean access after a load, and that access is flagged on `rsp_mark` so that software can write the bit back to its table.

Top module: `seg_guard`

## Requirements
- R1: After reset `rsp_valid` is 0 and every register is unloaded. An access to an unloaded register returns fault code 1 (absent).
- R2: An access presented with `acc_en` high in one cycle gets its response, with `rsp_valid` high, after the next clock edge. `rsp_valid` is low after cycles that have no access.
- R3: The descriptor layout is base in bits 23:0, limit in 39:24, present in 40, accessed in 41, privilege level in 43:42, and type in 47:44. A fault-free access returns `base + offset` modulo 2^24 with fault code 0. Any faulting access returns address 0.
- R4: In a normal segment (type bit 46 clear), an offset must not exceed the limit. A larger offset gives fault code 4 (limit).
- R5: In an expand-down segment (type bit 46 set), an offset must be strictly greater than the limit. An offset at or below the limit gives fault code 4.
- R6: Type bit 44 marks code and bit 45 marks readable (code) or writable (data). Access kinds are 0 read, 1 write, 2 execute, 3 invalid. The following give fault code 3 (rights): a write to code, a read of unreadable code, execution of data, a write to unwritable data, and kind 3.
- R7: The effective level is the larger of `acc_cpl` and the selector's bits 1:0. A descriptor level below the effective level gives fault code 2 (privilege).
- R8: A loaded register whose present bit is 0 gives fault code 1.
- R9: A register number of 6 or 7 gives fault code 5 (no such register).
- R10: When several faults apply, the code reported follows the order 5, 1, 2, 3, 4.
- R11: `rsp_mark` is 1 exactly on the first fault-free access after a load whose accessed bit was 0. From then on the stored accessed bit is 1.
- R12: If a load and an access hit the same register in the same cycle, the access uses the old contents. The new descriptor, including its accessed bit, takes effect for later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load a segment register |
| ld_idx | input | 3 | Register to load |
| ld_sel | input | 16 | Selector; bits 1:0 requested level |
| ld_desc | input | 64 | Descriptor |
| acc_en | input | 1 | Access request |
| acc_idx | input | 3 | Register used by the access |
| acc_off | input | 16 | Offset in the segment |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 invalid |
| acc_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 24 | Physical address, 0 on fault |
| rsp_fault | output | 3 | Fault code |
| rsp_mark | output | 1 | First clean access since load |

## Verification
A register load and an access to that same register can fall in the same clock edge. The accessed-bit update from that access competes with the load. The bench provokes this by reloading a register in the very cycle it is accessed. It then judges two things: the response must carry the old base and the old mark decision, and the following access must show the new base and must mark again, because the new descriptor arrived with its accessed bit clear.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = 24;
  localparam int LVL_W  = 2;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_PRIV   = 3'd2,
    FLT_RIGHTS = 3'd3,
    FLT_LIMIT  = 3'd4,
    FLT_NOREG  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  // type nibble: [0] code, [1] readable/writable, [2] expand-down, [3] spare
  typedef struct packed {
    logic [15:0]       spare;
    logic [3:0]        kind;
    logic [LVL_W-1:0]  dpl;
    logic              accessed;
    logic              present;
    logic [OFF_W-1:0]  limit;
    logic [ADDR_W-1:0] base;
  } seg_desc_t;

  function automatic logic [LVL_W-1:0] eff_level(input logic [LVL_W-1:0] cpl,
                                                 input logic [LVL_W-1:0] rpl);
    return (cpl > rpl) ? cpl : rpl;
  endfunction

  function automatic logic offset_ok(input logic [OFF_W-1:0] off,
                                     input logic [OFF_W-1:0] limit,
                                     input logic             down);
    if (down) return off > limit;
    return off <= limit;
  endfunction

  function automatic logic rights_ok(input logic [3:0] kind, input acc_e what);
    logic is_code, rw;
    is_code = kind[0];
    rw      = kind[1];
    case (what)
      ACC_READ:  return is_code ? rw : 1'b1;
      ACC_WRITE: return is_code ? 1'b0 : rw;
      ACC_EXEC:  return is_code;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] phys(input logic [ADDR_W-1:0] base,
                                             input logic [OFF_W-1:0]  off);
    return base + ADDR_W'(off);
  endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_guard_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  localparam int IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [SEL_W-1:0] ld_sel,
  input  seg_desc_t        ld_desc,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_desc_t        rd_desc,
  output logic [LVL_W-1:0] rd_rpl,
  output logic             rd_valid,
  output logic             rd_inrange
);

  seg_desc_t        desc_q [NUM_SEGS];
  logic [LVL_W-1:0] rpl_q  [NUM_SEGS];
  logic             vld_q  [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
    logic hit_ld, hit_mark;
    assign hit_ld   = ld_en && (ld_idx == IDX_W'(g));
    assign hit_mark = mark_en && (mark_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        desc_q[g] <= '0;
        rpl_q[g]  <= '0;
        vld_q[g]  <= 1'b0;
      end else if (hit_ld) begin
        desc_q[g] <= ld_desc;
        rpl_q[g]  <= ld_sel[LVL_W-1:0];
        vld_q[g]  <= 1'b1;
      end else if (hit_mark) begin
        desc_q[g].accessed <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_desc    = '0;
    rd_rpl     = '0;
    rd_valid   = 1'b0;
    rd_inrange = 1'b0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_desc    = desc_q[i];
        rd_rpl     = rpl_q[i];
        rd_valid   = vld_q[i];
        rd_inrange = 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_guard_pkg::*;
(
  input  seg_desc_t         desc,
  input  logic              valid,
  input  logic              inrange,
  input  logic [LVL_W-1:0]  rpl,
  input  logic [OFF_W-1:0]  off,
  input  acc_e              kind,
  input  logic [LVL_W-1:0]  cpl,
  output fault_e            fault,
  output logic [ADDR_W-1:0] addr,
  output logic              mark
);

  logic priv_bad, rights_bad, limit_bad;

  assign priv_bad   = desc.dpl < eff_level(cpl, rpl);
  assign rights_bad = !rights_ok(desc.kind, kind);
  assign limit_bad  = !offset_ok(off, desc.limit, desc.kind[2]);

  always_comb begin
    if (!inrange)                   fault = FLT_NOREG;
    else if (!valid || !desc.present) fault = FLT_ABSENT;
    else if (priv_bad)              fault = FLT_PRIV;
    else if (rights_bad)            fault = FLT_RIGHTS;
    else if (limit_bad)             fault = FLT_LIMIT;
    else                            fault = FLT_NONE;
  end

  assign addr = (fault == FLT_NONE) ? phys(desc.base, off) : '0;
  assign mark = (fault == FLT_NONE) && !desc.accessed;

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  localparam int IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  input  logic              acc_en,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_kind,
  input  logic [LVL_W-1:0]  acc_cpl,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [2:0]        rsp_fault,
  output logic              rsp_mark
);

  seg_desc_t         cur_desc;
  logic [LVL_W-1:0]  cur_rpl;
  logic              cur_valid, cur_inrange;
  fault_e            chk_fault;
  logic [ADDR_W-1:0] chk_addr;
  logic              chk_mark;
  logic              mark_fire;

  assign mark_fire = acc_en && chk_mark;

  seg_regfile #(.NUM_SEGS(NUM_SEGS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_idx     (ld_idx),
    .ld_sel     (ld_sel),
    .ld_desc    (seg_desc_t'(ld_desc)),
    .mark_en    (mark_fire),
    .mark_idx   (acc_idx),
    .rd_idx     (acc_idx),
    .rd_desc    (cur_desc),
    .rd_rpl     (cur_rpl),
    .rd_valid   (cur_valid),
    .rd_inrange (cur_inrange)
  );

  seg_check u_check (
    .desc    (cur_desc),
    .valid   (cur_valid),
    .inrange (cur_inrange),
    .rpl     (cur_rpl),
    .off     (acc_off),
    .kind    (acc_e'(acc_kind)),
    .cpl     (acc_cpl),
    .fault   (chk_fault),
    .addr    (chk_addr),
    .mark    (chk_mark)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= '0;
      rsp_mark  <= 1'b0;
    end else begin
      rsp_valid <= acc_en;
      rsp_addr  <= acc_en ? chk_addr : '0;
      rsp_fault <= acc_en ? chk_fault : FLT_NONE;
      rsp_mark  <= mark_fire;
    end
  end

endmodule

// File: rtl/seg_guard_sva.sv
module seg_guard_sva #(
  parameter int NUM_SEGS = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic [IDX_W-1:0] ld_idx,
  input logic             acc_en,
  input logic [IDX_W-1:0] acc_idx,
  input logic             mark_fire,
  input logic             rsp_valid,
  input logic [23:0]      rsp_addr,
  input logic [2:0]       rsp_fault,
  input logic             rsp_mark
);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !rsp_valid);

  assert_noreg_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && (int'(acc_idx) >= NUM_SEGS)) |=> (rsp_fault == 3'd5));

  assert_fault_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_addr == 24'd0));

  assert_mark_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mark |-> (rsp_valid && rsp_fault == 3'd0));

  assert_single_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_fire && $past(mark_fire) && acc_idx == $past(acc_idx))
      |-> $past(ld_en && ld_idx == acc_idx));

endmodule

bind seg_guard seg_guard_sva #(.NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_en     (ld_en),
  .ld_idx    (ld_idx),
  .acc_en    (acc_en),
  .acc_idx   (acc_idx),
  .mark_fire (mark_fire),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault),
  .rsp_mark  (rsp_mark)
);

// File: tb/test_seg_guard.sv
module test_seg_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [15:0] ld_sel = '0;
  logic [63:0] ld_desc = '0;
  logic        acc_en = 1'b0;
  logic [2:0]  acc_idx = '0;
  logic [15:0] acc_off = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  acc_cpl = '0;
  logic        rsp_valid;
  logic [23:0] rsp_addr;
  logic [2:0]  rsp_fault;
  logic        rsp_mark;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_guard i_seg_guard (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_sel(ld_sel), .ld_desc(ld_desc),
    .acc_en(acc_en), .acc_idx(acc_idx), .acc_off(acc_off),
    .acc_kind(acc_kind), .acc_cpl(acc_cpl),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_mark(rsp_mark)
  );

  // descriptor per R3/R6 layout
  function automatic logic [63:0] mk(input logic [23:0] base, input logic [15:0] lim,
                                     input bit p, input bit a, input logic [1:0] dpl,
                                     input bit code, input bit rw, input bit down);
    return {16'h0, 1'b0, down, rw, code, dpl, a, p, lim, base};
  endfunction

  // {idx, off, kind, cpl, fault, addr, mark}
  localparam int NV = 20;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 16'h0100, 2'd2, 2'd0, 3'd0, 24'h010100, 1'b1}, // R3 R11
    {3'd0, 16'h0FFF, 2'd0, 2'd0, 3'd0, 24'h010FFF, 1'b0}, // R4 edge
    {3'd0, 16'h1000, 2'd2, 2'd0, 3'd4, 24'h000000, 1'b0}, // R4
    {3'd0, 16'h0010, 2'd1, 2'd0, 3'd3, 24'h000000, 1'b0}, // R6
    {3'd0, 16'h0010, 2'd2, 2'd3, 3'd2, 24'h000000, 1'b0}, // R7
    {3'd1, 16'h0100, 2'd1, 2'd3, 3'd0, 24'h200100, 1'b1}, // R5
    {3'd1, 16'h00FF, 2'd0, 2'd3, 3'd4, 24'h000000, 1'b0}, // R5 edge
    {3'd1, 16'h0000, 2'd1, 2'd0, 3'd4, 24'h000000, 1'b0}, // R5 R7
    {3'd2, 16'h0200, 2'd0, 2'd0, 3'd0, 24'h000100, 1'b0}, // R3 wrap
    {3'd2, 16'h0001, 2'd2, 2'd0, 3'd3, 24'h000000, 1'b0}, // R6
    {3'd3, 16'h0005, 2'd0, 2'd1, 3'd2, 24'h000000, 1'b0}, // R7 rpl
    {3'd3, 16'h0020, 2'd1, 2'd1, 3'd2, 24'h000000, 1'b0}, // R10
    {3'd4, 16'h0000, 2'd0, 2'd0, 3'd1, 24'h000000, 1'b0}, // R8
    {3'd5, 16'h0010, 2'd0, 2'd3, 3'd3, 24'h000000, 1'b0}, // R6
    {3'd5, 16'h0010, 2'd2, 2'd3, 3'd0, 24'h050010, 1'b1}, // R11
    {3'd5, 16'h0200, 2'd1, 2'd0, 3'd3, 24'h000000, 1'b0}, // R10
    {3'd6, 16'h0000, 2'd0, 2'd0, 3'd5, 24'h000000, 1'b0}, // R9
    {3'd7, 16'h0000, 2'd0, 2'd0, 3'd5, 24'h000000, 1'b0}, // R9
    {3'd0, 16'h0000, 2'd3, 2'd0, 3'd3, 24'h000000, 1'b0}, // R6
    {3'd2, 16'hFFFF, 2'd1, 2'd0, 3'd0, 24'h00FEFF, 1'b0}  // R3 wrap
  };

  task automatic load(input logic [2:0] idx, input logic [15:0] sel, input logic [63:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_sel = sel; ld_desc = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [2:0] f, input logic [23:0] a,
                       input logic m);
    n_cmp++;
    if (rsp_valid !== 1'b1 || rsp_fault !== f || rsp_addr !== a || rsp_mark !== m) begin
      n_bad++;
      $display("FAIL %s: got v=%0b f=%0d a=%06h m=%0b, want v=1 f=%0d a=%06h m=%0b",
               req, rsp_valid, rsp_fault, rsp_addr, rsp_mark, f, a, m);
    end
  endtask

  task automatic access(input logic [2:0] idx, input logic [15:0] off,
                        input logic [1:0] k, input logic [1:0] cpl);
    @(negedge clk);
    acc_en = 1'b1; acc_idx = idx; acc_off = off; acc_kind = k; acc_cpl = cpl;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got rsp_valid=%0b, want 0", rsp_valid);
    end
    // R1: unloaded register reads absent
    access(3'd0, 16'h0, 2'd0, 2'd0);
    check("R1", 3'd1, 24'h0, 1'b0);
    @(negedge clk);
    // R2: quiet cycle
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: got rsp_valid=%0b, want 0", rsp_valid);
    end

    load(3'd0, 16'h0008, mk(24'h010000, 16'h0FFF, 1, 0, 2'd0, 1, 1, 0));
    load(3'd1, 16'h0013, mk(24'h200000, 16'h00FF, 1, 0, 2'd3, 0, 1, 1));
    load(3'd2, 16'h0020, mk(24'hFFFF00, 16'hFFFF, 1, 1, 2'd3, 0, 1, 0));
    load(3'd3, 16'h002E, mk(24'h030000, 16'h0010, 1, 0, 2'd1, 0, 0, 0));
    load(3'd4, 16'h0030, mk(24'h040000, 16'hFFFF, 0, 0, 2'd3, 0, 1, 0));
    load(3'd5, 16'h0038, mk(24'h050000, 16'h00FF, 1, 0, 2'd3, 1, 0, 0));

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      access(v[50:48], v[47:32], v[31:30], v[29:28]);
      check($sformatf("vector %0d (R2-R11)", i), v[27:25], v[24:1], v[0]);
    end

    // R11: reload re-arms marking
    load(3'd0, 16'h0008, mk(24'h010000, 16'h0FFF, 1, 0, 2'd0, 1, 1, 0));
    access(3'd0, 16'h0004, 2'd2, 2'd0);
    check("R11 rearm", 3'd0, 24'h010004, 1'b1);
    access(3'd0, 16'h0004, 2'd2, 2'd0);
    check("R11 once", 3'd0, 24'h010004, 1'b0);
    // R11: loaded with accessed already set never marks
    load(3'd3, 16'h0000, mk(24'h060000, 16'h00FF, 1, 1, 2'd3, 0, 1, 0));
    access(3'd3, 16'h0001, 2'd1, 2'd0);
    check("R11 preset", 3'd0, 24'h060001, 1'b0);

    // R12: load and access of register 1 in the same cycle
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'd1; ld_sel = 16'h0000;
    ld_desc = mk(24'h100000, 16'hFFFF, 1, 0, 2'd3, 0, 1, 0);
    acc_en = 1'b1; acc_idx = 3'd1; acc_off = 16'h0180; acc_kind = 2'd0; acc_cpl = 2'd0;
    @(negedge clk);
    ld_en = 1'b0; acc_en = 1'b0;
    check("R12 old contents", 3'd0, 24'h200180, 1'b0);
    access(3'd1, 16'h0010, 2'd0, 2'd0);
    check("R12 new contents", 3'd0, 24'h100010, 1'b1);

    // R12: fresh register accessed and reloaded together; the load wins
    load(3'd5, 16'h0000, mk(24'h070000, 16'h00FF, 1, 0, 2'd3, 1, 1, 0));
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'd5; ld_sel = 16'h0000;
    ld_desc = mk(24'h080000, 16'h00FF, 1, 0, 2'd3, 1, 1, 0);
    acc_en = 1'b1; acc_idx = 3'd5; acc_off = 16'h0002; acc_kind = 2'd2; acc_cpl = 2'd0;
    @(negedge clk);
    ld_en = 1'b0; acc_en = 1'b0;
    check("R12 mark old", 3'd0, 24'h070002, 1'b1);
    access(3'd5, 16'h0003, 2'd2, 2'd0);
    check("R12 load wins", 3'd0, 24'h080003, 1'b1);

    // R1: reset clears loaded registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(3'd2, 16'h0000, 2'd0, 2'd0);
    check("R1 after reset", 3'd1, 24'h0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule